// File: doc/BRIEF.md
# Bus Hold and External Access Responder

This block sits inside a processor-like device and answers two kinds of requests from an outside master. The first is a bus hold request. The block waits until the device's own external access has finished. It then floats the address and memory control lines and acknowledges the request. When the request is withdrawn, the block gives the bus back.

The second is a separate bus request that asks for direct access to the device's internal memory. The block grants it with an acknowledge after a fixed delay. While the grant is held, the outside master reads and writes internal memory with a strobe, a read/write line and an address. Read data comes from a simple internal memory port. Writes leave the block through a valid/ready port.

All four asynchronous control inputs pass through two-flop synchronizers before use. The handshake delays are set as parameters in half-clock units (H), and each must be an even number. Read data is driven on a split data bus: `xdata_out` with the enable `xdata_oe`. Write data arrives on `xdata_in`.

Write port back-pressure works as follows:
- A write is offered with `mem_wr_valid`. It is taken on any clock edge where `mem_wr_ready` is high.
- While the write waits, its address and data stay fixed.
- The outside master cannot be stalled. A strobe that completes while a write is still waiting is discarded.

Top module: `bus_hold_responder`

## Requirements
- R1: After reset, `holda_n` and `iaq_n` are high, and `bus_float`, `xdata_oe` and `mem_wr_valid` are low.
- R2: With `ext_busy` low, `holda_n` falls on rising edge number 3 + HOLD_LAT_H/2, counting the first edge that samples `hold_n` low as edge 1. With the default parameters this is the 5th edge.
- R3: While `ext_busy` is high, `holda_n` stays high and `bus_float` stays low, even if `hold_n` is low. Once `hold_n` has been pending long enough, `bus_float` rises on the first edge that samples `ext_busy` low, and `holda_n` falls on the next edge.
- R4: `bus_float` rises one clock before `holda_n` falls, and stays high for as long as `holda_n` is low.
- R5: `holda_n` returns high on the 3rd rising edge after `hold_n` is first sampled high. With `iaq_n` high, `bus_float` falls one edge later, so the bus is driven only after `holda_n` has risen.
- R6: `iaq_n` falls on edge 2 + IAQ_ON_H/2 after `xbr_n` is first sampled low (the 4th edge by default). It rises on edge 2 + IAQ_OFF_H/2 after `xbr_n` is first sampled high (the 3rd edge by default).
- R7: While `iaq_n` is low and `xrw` is high (read) at the pins and in synchronized form, `xdata_oe` is high. `xdata_out` then carries the memory word at the address `xaddr` held one clock earlier. `xdata_oe` falls in the same clock in which `iaq_n` rises.
- R8: `xdata_oe` falls at once, with no clock edge, when `xrw` goes low.
- R9: A write is issued when `xstrb_n` rises while `iaq_n` is low and `xrw` is sampled low. `mem_wr_valid` rises on the 3rd edge after `xstrb_n` is first sampled high. The write carries the last `xaddr` and `xdata_in` seen while `xstrb_n` was low. A strobe that rises while `iaq_n` is high issues no write.
- R10: While `mem_wr_valid` is high and `mem_wr_ready` is low, the valid flag, `mem_waddr` and `mem_wdata` all hold. The valid flag drops on the edge after the handshake completes, unless a new write is issued.
- R11: A strobe that completes while a write is still waiting is discarded. Memory at that strobe's address is left unchanged.
- R12: If `iaq_n` is low when the hold is released, `bus_float` stays high until the edge after `iaq_n` has returned high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Device clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| hold_n | input | 1 | Bus hold request from outside, active low, asynchronous |
| holda_n | output | 1 | Hold acknowledge, active low |
| ext_busy | input | 1 | The device's own external access is in progress |
| bus_float | output | 1 | Address and memory control drivers are in high impedance |
| xbr_n | input | 1 | Request for access to internal memory, active low, asynchronous |
| iaq_n | output | 1 | Internal memory access granted, active low |
| xstrb_n | input | 1 | Outside master strobe, active low |
| xrw | input | 1 | Outside master direction: 1 = read, 0 = write |
| xaddr | input | AW | Outside master address |
| xdata_in | input | DW | Write data from the outside master |
| xdata_out | output | DW | Read data toward the outside master |
| xdata_oe | output | 1 | Drive enable for `xdata_out` |
| mem_raddr | output | AW | Internal memory read address |
| mem_rdata | input | DW | Internal memory read data (combinational read) |
| mem_wr_valid | output | 1 | Write request toward internal memory |
| mem_wr_ready | input | 1 | Internal memory accepts the write |
| mem_waddr | output | AW | Write address |
| mem_wdata | output | DW | Write data |

## Verification
Each stimulus is driven on a falling clock edge, and the check waits a known number of rising edges before sampling at the next falling edge. The counts are:
- Two synchronizer edges plus the FSM edge plus HOLD_LAT_H/2 for the hold acknowledge.
- Three edges for its release.
- Two edges plus the half-clock count, in clocks, for each change of `iaq_n`.
- Three edges from strobe release to a write request.

The timing checks also sample one edge early, to show the output has not moved yet. The combinational release of the data enable is checked one time step after `xrw` falls, before any clock edge.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;
  typedef enum logic [2:0] {
    HS_IDLE,
    HS_WAIT,
    HS_FLOAT,
    HS_GRANT,
    HS_REL
  } hold_state_e;
endpackage

// File: rtl/bh_sync.sv
module bh_sync #(
  parameter int             W       = 1,
  parameter int             STAGES  = 2,
  parameter logic [W-1:0]   RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= RST_VAL;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/bh_hold_fsm.sv
module bh_hold_fsm
  import bus_hold_pkg::*;
#(
  parameter int HOLD_LAT_H = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  input  logic ext_busy,
  input  logic iaq_n,
  output logic holda_n,
  output logic bus_float
);
  localparam int HOLD_CYC = HOLD_LAT_H / 2;
  localparam int FLOAT_AT = HOLD_CYC - 2;
  localparam int CW       = (FLOAT_AT > 0) ? $clog2(FLOAT_AT + 1) : 1;
  localparam logic [CW-1:0] FLOAT_CNT = CW'(FLOAT_AT);

  hold_state_e   st;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st  <= HS_IDLE;
      cnt <= '0;
    end else begin
      case (st)
        HS_IDLE: if (hold_req) begin
          st  <= HS_WAIT;
          cnt <= '0;
        end
        HS_WAIT: begin
          if (!hold_req)                           st  <= HS_IDLE;
          else if (cnt == FLOAT_CNT && !ext_busy)  st  <= HS_FLOAT;
          else if (cnt != FLOAT_CNT)               cnt <= cnt + 1'b1;
        end
        HS_FLOAT: st <= HS_GRANT;
        HS_GRANT: if (!hold_req) st <= HS_REL;
        HS_REL:   if (iaq_n)     st <= HS_IDLE;
        default:  st <= HS_IDLE;
      endcase
    end
  end

  assign holda_n   = (st != HS_GRANT);
  assign bus_float = (st == HS_FLOAT) || (st == HS_GRANT) || (st == HS_REL);
endmodule

// File: rtl/bh_iaq_ctrl.sv
module bh_iaq_ctrl #(
  parameter int IAQ_ON_H  = 4,
  parameter int IAQ_OFF_H = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic xreq,
  output logic iaq_n
);
  localparam int ON_CYC  = IAQ_ON_H / 2;
  localparam int OFF_CYC = IAQ_OFF_H / 2;
  localparam int MAXC    = (ON_CYC > OFF_CYC) ? ON_CYC : OFF_CYC;
  localparam int CW      = (MAXC > 1) ? $clog2(MAXC) : 1;
  localparam logic [CW-1:0] ON_LAST  = CW'(ON_CYC - 1);
  localparam logic [CW-1:0] OFF_LAST = CW'(OFF_CYC - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      iaq_n <= 1'b1;
      cnt   <= '0;
    end else if (iaq_n) begin
      if (!xreq)              cnt <= '0;
      else if (cnt == ON_LAST) begin
        iaq_n <= 1'b0;
        cnt   <= '0;
      end else                cnt <= cnt + 1'b1;
    end else begin
      if (xreq)               cnt <= '0;
      else if (cnt == OFF_LAST) begin
        iaq_n <= 1'b1;
        cnt   <= '0;
      end else                cnt <= cnt + 1'b1;
    end
  end
endmodule

// File: rtl/bh_xport.sv
module bh_xport #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          iaq_n,
  input  logic          rd_s,
  input  logic          strobe_s,
  input  logic          xrw,
  input  logic          xstrb_n,
  input  logic [AW-1:0] xaddr,
  input  logic [DW-1:0] xdata_in,
  output logic [DW-1:0] xdata_out,
  output logic          xdata_oe,
  output logic [AW-1:0] mem_raddr,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_wr_valid,
  input  logic          mem_wr_ready,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata
);
  logic [AW-1:0] cap_a;
  logic [DW-1:0] cap_d;
  logic          strobe_prev;
  logic          strobe_rise;
  logic          slot_free;

  assign strobe_rise = strobe_s && !strobe_prev;
  assign slot_free   = !mem_wr_valid || mem_wr_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_a        <= '0;
      cap_d        <= '0;
      strobe_prev  <= 1'b1;
      mem_raddr    <= '0;
      mem_wr_valid <= 1'b0;
      mem_waddr    <= '0;
      mem_wdata    <= '0;
    end else begin
      strobe_prev <= strobe_s;
      mem_raddr   <= xaddr;
      if (!xstrb_n) begin
        cap_a <= xaddr;
        cap_d <= xdata_in;
      end
      if (mem_wr_valid && mem_wr_ready) mem_wr_valid <= 1'b0;
      if (strobe_rise && !iaq_n && !rd_s && slot_free) begin
        mem_wr_valid <= 1'b1;
        mem_waddr    <= cap_a;
        mem_wdata    <= cap_d;
      end
    end
  end

  assign xdata_out = mem_rdata;
  assign xdata_oe  = !iaq_n && rd_s && xrw;
endmodule

// File: rtl/bus_hold_responder.sv
module bus_hold_responder #(
  parameter int AW         = 8,
  parameter int DW         = 16,
  parameter int HOLD_LAT_H = 4,
  parameter int IAQ_ON_H   = 4,
  parameter int IAQ_OFF_H  = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hold_n,
  output logic          holda_n,
  input  logic          ext_busy,
  output logic          bus_float,
  input  logic          xbr_n,
  output logic          iaq_n,
  input  logic          xstrb_n,
  input  logic          xrw,
  input  logic [AW-1:0] xaddr,
  input  logic [DW-1:0] xdata_in,
  output logic [DW-1:0] xdata_out,
  output logic          xdata_oe,
  output logic [AW-1:0] mem_raddr,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_wr_valid,
  input  logic          mem_wr_ready,
  output logic [AW-1:0] mem_waddr,
  output logic [DW-1:0] mem_wdata
);
  logic hold_n_s, xbr_n_s, strobe_s, rd_s;

  bh_sync #(.W(4), .STAGES(2), .RST_VAL(4'hF)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({hold_n, xbr_n, xstrb_n, xrw}),
    .q     ({hold_n_s, xbr_n_s, strobe_s, rd_s})
  );

  bh_iaq_ctrl #(.IAQ_ON_H(IAQ_ON_H), .IAQ_OFF_H(IAQ_OFF_H)) u_iaq (
    .clk   (clk),
    .rst_n (rst_n),
    .xreq  (!xbr_n_s),
    .iaq_n (iaq_n)
  );

  bh_hold_fsm #(.HOLD_LAT_H(HOLD_LAT_H)) u_hold (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_req  (!hold_n_s),
    .ext_busy  (ext_busy),
    .iaq_n     (iaq_n),
    .holda_n   (holda_n),
    .bus_float (bus_float)
  );

  bh_xport #(.AW(AW), .DW(DW)) u_xport (
    .clk          (clk),
    .rst_n        (rst_n),
    .iaq_n        (iaq_n),
    .rd_s         (rd_s),
    .strobe_s     (strobe_s),
    .xrw          (xrw),
    .xstrb_n      (xstrb_n),
    .xaddr        (xaddr),
    .xdata_in     (xdata_in),
    .xdata_out    (xdata_out),
    .xdata_oe     (xdata_oe),
    .mem_raddr    (mem_raddr),
    .mem_rdata    (mem_rdata),
    .mem_wr_valid (mem_wr_valid),
    .mem_wr_ready (mem_wr_ready),
    .mem_waddr    (mem_waddr),
    .mem_wdata    (mem_wdata)
  );
endmodule

// File: rtl/bus_hold_responder_chk.sv
module bus_hold_responder_chk #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          holda_n,
  input logic          bus_float,
  input logic          ext_busy,
  input logic          iaq_n,
  input logic          xrw,
  input logic          xdata_oe,
  input logic          mem_wr_valid,
  input logic          mem_wr_ready,
  input logic [AW-1:0] mem_waddr,
  input logic [DW-1:0] mem_wdata
);
  AST_FLOAT_COVERS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    !holda_n |-> bus_float); // R4

  AST_FLOAT_LEADS_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(holda_n) |-> $past(bus_float)); // R4

  AST_NO_FLOAT_DURING_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_float) |-> !$past(ext_busy)); // R3

  AST_DRIVE_AFTER_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(holda_n) |-> bus_float); // R5

  AST_OE_QUALIFIED: assert property (@(posedge clk) disable iff (!rst_n)
    xdata_oe |-> (!iaq_n && xrw)); // R7

  AST_WRITE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr_valid && !mem_wr_ready) |=>
      (mem_wr_valid && $stable(mem_waddr) && $stable(mem_wdata))); // R10

  AST_IAQ_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_float) |-> $past(iaq_n)); // R12
endmodule

bind bus_hold_responder bus_hold_responder_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .holda_n      (holda_n),
  .bus_float    (bus_float),
  .ext_busy     (ext_busy),
  .iaq_n        (iaq_n),
  .xrw          (xrw),
  .xdata_oe     (xdata_oe),
  .mem_wr_valid (mem_wr_valid),
  .mem_wr_ready (mem_wr_ready),
  .mem_waddr    (mem_waddr),
  .mem_wdata    (mem_wdata)
);

// File: tb/bus_hold_responder_tb.sv
`timescale 1ns/1ps
module bus_hold_responder_tb;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int NV = 6;
  localparam logic [AW+DW-1:0] VEC [NV] = '{
    24'h01_BEEF, 24'h17_0000, 24'h80_FFFF,
    24'hFF_1234, 24'h3C_8001, 24'hC5_5A5A
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          hold_n = 1'b1, ext_busy = 1'b0, xbr_n = 1'b1;
  logic          xstrb_n = 1'b1, xrw = 1'b1;
  logic [AW-1:0] xaddr = '0;
  logic [DW-1:0] xdata_in = '0;
  logic          mem_wr_ready = 1'b1;
  logic          holda_n, bus_float, iaq_n, xdata_oe, mem_wr_valid;
  logic [DW-1:0] xdata_out, mem_rdata, mem_wdata;
  logic [AW-1:0] mem_raddr, mem_waddr;
  logic [DW-1:0] bmem [256];
  int            nchk = 0, nfail = 0;
  bit            done = 0;

  always #2.5 clk = ~clk;

  bus_hold_responder #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .hold_n(hold_n), .holda_n(holda_n),
    .ext_busy(ext_busy), .bus_float(bus_float), .xbr_n(xbr_n), .iaq_n(iaq_n),
    .xstrb_n(xstrb_n), .xrw(xrw), .xaddr(xaddr), .xdata_in(xdata_in),
    .xdata_out(xdata_out), .xdata_oe(xdata_oe), .mem_raddr(mem_raddr),
    .mem_rdata(mem_rdata), .mem_wr_valid(mem_wr_valid),
    .mem_wr_ready(mem_wr_ready), .mem_waddr(mem_waddr), .mem_wdata(mem_wdata)
  );

  assign mem_rdata = bmem[mem_raddr];

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) bmem[i] <= 16'hA000 | 16'(i);
    end else if (mem_wr_valid && mem_wr_ready) begin
      bmem[mem_waddr] <= mem_wdata;
    end
  end

  task automatic tick(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic strobe_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
    xaddr = a; xdata_in = d; xstrb_n = 1'b0;
    tick(2);
    xstrb_n = 1'b1;
    tick(3);
  endtask

  initial begin
    tick(3);
    rst_n = 1'b1;
    tick(1);
    // R1 reset state
    chk("R1 holda_n", holda_n, 1); chk("R1 iaq_n", iaq_n, 1);
    chk("R1 bus_float", bus_float, 0); chk("R1 xdata_oe", xdata_oe, 0);
    chk("R1 mem_wr_valid", mem_wr_valid, 0);

    // R2 / R4 grant latency, R5 release
    hold_n = 1'b0;
    tick(4);
    chk("R2 holda_n early", holda_n, 1); chk("R4 float leads", bus_float, 1);
    tick(1);
    chk("R2 holda_n low", holda_n, 0); chk("R4 float held", bus_float, 1);
    hold_n = 1'b1;
    tick(3);
    chk("R5 holda_n high", holda_n, 1); chk("R5 float still", bus_float, 1);
    tick(1);
    chk("R5 float off", bus_float, 0);

    // R3 busy holds off the grant
    ext_busy = 1'b1; hold_n = 1'b0;
    tick(8);
    chk("R3 holda_n held", holda_n, 1); chk("R3 float held", bus_float, 0);
    ext_busy = 1'b0;
    tick(1);
    chk("R3 float", bus_float, 1); chk("R3 holda_n not yet", holda_n, 1);
    tick(1);
    chk("R3 holda_n low", holda_n, 0);
    hold_n = 1'b1;
    tick(5);
    chk("R5 float off after busy case", bus_float, 0);

    // R6 IAQ on, R7 read at address 0
    xbr_n = 1'b0;
    tick(3);
    chk("R6 iaq_n early", iaq_n, 1);
    tick(1);
    chk("R6 iaq_n low", iaq_n, 0);
    chk("R7 oe", xdata_oe, 1); chk("R7 data", xdata_out, 16'hA000);

    // Vector table: write then read back (R8, R9, R7)
    for (int v = 0; v < NV; v++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      {a, d} = VEC[v];
      xrw = 1'b0;
      #1 chk("R8 oe drops with xrw", xdata_oe, 0);
      tick(2);
      strobe_write(a, d);
      chk("R9 wr_valid", mem_wr_valid, 1);
      chk("R9 waddr", mem_waddr, a); chk("R9 wdata", mem_wdata, d);
      tick(1);
      chk("R10 valid clears", mem_wr_valid, 0);
      xrw = 1'b1;
      tick(3);
      chk("R7 read oe", xdata_oe, 1); chk("R7 read data", xdata_out, d);
    end

    // R10 back-pressure, R11 dropped strobe
    mem_wr_ready = 1'b0; xrw = 1'b0;
    tick(2);
    strobe_write(8'h40, 16'h1111);
    tick(4);
    chk("R10 held valid", mem_wr_valid, 1); chk("R10 held addr", mem_waddr, 8'h40);
    strobe_write(8'h41, 16'h2222);
    chk("R11 addr kept", mem_waddr, 8'h40); chk("R11 data kept", mem_wdata, 16'h1111);
    mem_wr_ready = 1'b1;
    tick(1);
    chk("R10 valid after ready", mem_wr_valid, 0);
    xaddr = 8'h41; xrw = 1'b1;
    tick(3);
    chk("R11 mem 41 unchanged", xdata_out, 16'hA041);
    xaddr = 8'h40;
    tick(1);
    chk("R10 mem 40 written", xdata_out, 16'h1111);

    // R6 IAQ off, R7 oe release
    xbr_n = 1'b1;
    tick(2);
    chk("R6 iaq_n still low", iaq_n, 0); chk("R7 oe still", xdata_oe, 1);
    tick(1);
    chk("R6 iaq_n high", iaq_n, 1); chk("R7 oe off", xdata_oe, 0);

    // R9 strobe with iaq_n high is ignored
    xrw = 1'b0;
    tick(2);
    strobe_write(8'h22, 16'h3333);
    tick(1);
    chk("R9 no write without grant", mem_wr_valid, 0);

    // R12 grant priority at hold release
    xbr_n = 1'b0;
    tick(4);
    chk("R12 iaq_n low", iaq_n, 0);
    hold_n = 1'b0;
    tick(5);
    chk("R12 holda_n low", holda_n, 0);
    hold_n = 1'b1;
    tick(3);
    chk("R12 holda_n high", holda_n, 1); chk("R12 float kept", bus_float, 1);
    tick(6);
    chk("R12 float still kept", bus_float, 1);
    xbr_n = 1'b1;
    tick(3);
    chk("R12 iaq_n high", iaq_n, 1); chk("R12 float until iaq", bus_float, 1);
    tick(1);
    chk("R12 float off", bus_float, 0);

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule